// File: doc/BRIEF.md
# Boundary-Scan Test Access Port Controller

This block is the serial test port of a chip. A 16-state controller advances on the rising edge of the test clock under the mode-select input. An active-low asynchronous reset can force it back to its idle reset state. A 4-bit instruction register is loaded serially. The instruction in force picks which data register sits between the serial input and the serial output. The choices are a one-bit pass-through register, a 32-bit identification word, or a 214-bit boundary chain.

The boundary chain has a parallel capture vector on the input side. On the output side it has a parallel update latch. Logic next to the block uses these two vectors to sample and to drive the real pads. Serial output changes only on the falling test-clock edge. A separate output-enable tells the pad driver when the serial output is meaningful.

Top module: `jtag_tap_ctrl`

## Requirements
- R1: Driving `trst_n` low immediately returns the controller to Test-Logic-Reset. It sets the active instruction to 4'h5, drops `tdo_oe` and clears `bsr_upd_o`, with no clock edge needed.
- R2: Five consecutive rising edges of `tck` with `tms` high reach Test-Logic-Reset from any state. The active instruction then becomes 4'h5. Four such edges starting from Shift-DR are not enough and leave the instruction unchanged.
- R3: Entering Capture-IR loads 4'b0001 into the instruction shift stage. The first four bits seen on `tdo` in Shift-IR are therefore 1, 0, 0, 0, shifted out least significant bit first while `tdi` enters at bit 3.
- R4: A newly shifted instruction appears on `cur_instr_o` at the falling `tck` edge spent in Update-IR. After the rising edge that enters Update-IR, the old instruction is still shown. The instruction changes in no other state except Test-Logic-Reset.
- R5: Opcode 4'hF selects the one-bit pass-through register, and so does every opcode other than 4'h0, 4'h1, 4'h2 and 4'h5. It captures 0, so during Shift-DR `tdo` shows 0 first and then each `tdi` bit one shift later.
- R6: Opcode 4'h5 selects the 32-bit identification word, shifted out least significant bit first. Its layout is version in bits 31:28 (parameter), 6'b000001 in bits 27:22, 10'b0000110000 in bits 21:12, 11'b00000001110 in bits 11:1, and 1 in bit 0.
- R7: Opcodes 4'h0, 4'h1 and 4'h2 each select the 214-bit boundary chain. Capture-DR loads `bsr_cap_i` into it. Index 0 is the `tdi` end and index 213 the `tdo` end, so `bsr_cap_i[213]` is the first bit out.
- R8: On the falling edge in Update-DR with a boundary opcode active, the chain is copied to `bsr_upd_o`. After shifting bits d0..d213 in order, `bsr_upd_o[j]` equals d(213-j). A DR scan under any other instruction leaves `bsr_upd_o` unchanged.
- R9: `tdo` and `tdo_oe` change only on the falling `tck` edge. `tdo_oe` is high exactly while the controller is in Shift-IR or Shift-DR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low test reset |
| tms | input | 1 | Mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial data in, sampled on rising `tck` |
| bsr_cap_i | input | 214 | Parallel values captured into the boundary chain |
| bsr_upd_o | output | 214 | Boundary update latch driven toward the pads |
| tdo | output | 1 | Serial data out, changes on falling `tck` |
| tdo_oe | output | 1 | High when `tdo` should be driven, low for high impedance |
| cur_instr_o | output | 4 | Instruction currently in force |

## Verification
Controller state and shift registers move on the rising edge. The serial output, its enable, the active instruction and the update latch move on the following falling edge. Each bench step therefore drives `tms`/`tdi` one time unit after a rising edge. It samples `tdo` and `tdo_oe` one unit after the falling edge, which is the bit belonging to the state the controller holds in that cycle. The instruction switch is checked on both sides of the Update-IR falling edge: one unit after the rising edge it must still be old, and one unit after the falling edge it must be new. The update latch is compared only after the scan has left Update-DR.

// File: rtl/tap_pkg.sv
package tap_pkg;

  localparam int IR_W = 4;
  localparam int ID_W = 32;

  typedef enum logic [3:0] {
    ST_RESET, ST_IDLE,
    ST_DR_SEL, ST_DR_CAP, ST_DR_SHF, ST_DR_EX1, ST_DR_PAU, ST_DR_EX2, ST_DR_UPD,
    ST_IR_SEL, ST_IR_CAP, ST_IR_SHF, ST_IR_EX1, ST_IR_PAU, ST_IR_EX2, ST_IR_UPD
  } tap_state_t;

  typedef enum logic [1:0] {SEL_PASS, SEL_IDENT, SEL_CHAIN} dr_sel_t;

  localparam logic [IR_W-1:0] OP_EXT    = 4'h0;
  localparam logic [IR_W-1:0] OP_SMP    = 4'h1;
  localparam logic [IR_W-1:0] OP_LPS    = 4'h2;
  localparam logic [IR_W-1:0] OP_IDENT  = 4'h5;
  localparam logic [IR_W-1:0] OP_PASS   = 4'hF;
  localparam logic [IR_W-1:0] IR_CAPVAL = 4'b0001;

  function automatic tap_state_t tap_next(input tap_state_t s, input logic m);
    case (s)
      ST_RESET:  return m ? ST_RESET  : ST_IDLE;
      ST_IDLE:   return m ? ST_DR_SEL : ST_IDLE;
      ST_DR_SEL: return m ? ST_IR_SEL : ST_DR_CAP;
      ST_DR_CAP: return m ? ST_DR_EX1 : ST_DR_SHF;
      ST_DR_SHF: return m ? ST_DR_EX1 : ST_DR_SHF;
      ST_DR_EX1: return m ? ST_DR_UPD : ST_DR_PAU;
      ST_DR_PAU: return m ? ST_DR_EX2 : ST_DR_PAU;
      ST_DR_EX2: return m ? ST_DR_UPD : ST_DR_SHF;
      ST_DR_UPD: return m ? ST_DR_SEL : ST_IDLE;
      ST_IR_SEL: return m ? ST_RESET  : ST_IR_CAP;
      ST_IR_CAP: return m ? ST_IR_EX1 : ST_IR_SHF;
      ST_IR_SHF: return m ? ST_IR_EX1 : ST_IR_SHF;
      ST_IR_EX1: return m ? ST_IR_UPD : ST_IR_PAU;
      ST_IR_PAU: return m ? ST_IR_EX2 : ST_IR_PAU;
      ST_IR_EX2: return m ? ST_IR_UPD : ST_IR_SHF;
      default:   return m ? ST_DR_SEL : ST_IDLE;
    endcase
  endfunction

  function automatic dr_sel_t op_decode(input logic [IR_W-1:0] op);
    case (op)
      OP_EXT, OP_SMP, OP_LPS: return SEL_CHAIN;
      OP_IDENT:               return SEL_IDENT;
      default:                return SEL_PASS;
    endcase
  endfunction

  function automatic logic [ID_W-1:0] ident_word(input logic [3:0] ver);
    return {ver, 6'b000001, 10'b0000110000, 11'b00000001110, 1'b1};
  endfunction

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
  import tap_pkg::*;
(
  input  logic       tck,
  input  logic       trst_n,
  input  logic       tms,
  output tap_state_t state
);
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) state <= ST_RESET;
    else         state <= tap_next(state, tms);
  end
endmodule

// File: rtl/tap_ir.sv
module tap_ir
  import tap_pkg::*;
(
  input  logic            tck,
  input  logic            trst_n,
  input  logic            tdi,
  input  tap_state_t      state,
  output logic            ir_lsb,
  output logic [IR_W-1:0] instr
);
  logic [IR_W-1:0] ir_sr;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)                 ir_sr <= '0;
    else if (state == ST_IR_CAP) ir_sr <= IR_CAPVAL;
    else if (state == ST_IR_SHF) ir_sr <= {tdi, ir_sr[IR_W-1:1]};
  end

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n)                 instr <= OP_IDENT;
    else if (state == ST_RESET)  instr <= OP_IDENT;
    else if (state == ST_IR_UPD) instr <= ir_sr;
  end

  assign ir_lsb = ir_sr[0];
endmodule

// File: rtl/tap_dr.sv
module tap_dr
  import tap_pkg::*;
#(
  parameter int         CHAIN_LEN = 214,
  parameter logic [3:0] ID_VER    = 4'h2
) (
  input  logic                 tck,
  input  logic                 trst_n,
  input  logic                 tdi,
  input  tap_state_t           state,
  input  logic [IR_W-1:0]      instr,
  input  logic [CHAIN_LEN-1:0] chain_cap,
  output logic [CHAIN_LEN-1:0] chain_upd,
  output logic                 dr_lsb
);
  localparam logic [ID_W-1:0] ID_VAL = ident_word(ID_VER);

  dr_sel_t              sel;
  logic                 pass_q;
  logic [ID_W-1:0]      id_sr;
  logic [CHAIN_LEN-1:0] chain_sr;
  logic                 cap_ev, shf_ev, upd_ev;

  assign sel    = op_decode(instr);
  assign cap_ev = (state == ST_DR_CAP);
  assign shf_ev = (state == ST_DR_SHF);
  assign upd_ev = (state == ST_DR_UPD) && (sel == SEL_CHAIN);

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      pass_q <= 1'b0;
      id_sr  <= '0;
    end else if (cap_ev) begin
      pass_q <= 1'b0;
      id_sr  <= ID_VAL;
    end else if (shf_ev) begin
      pass_q <= tdi;
      id_sr  <= {tdi, id_sr[ID_W-1:1]};
    end
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)                            chain_sr <= '0;
    else if (cap_ev && sel == SEL_CHAIN)    chain_sr <= chain_cap;
    else if (shf_ev && sel == SEL_CHAIN)    chain_sr <= {chain_sr[CHAIN_LEN-2:0], tdi};
  end

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n)     chain_upd <= '0;
    else if (upd_ev) chain_upd <= chain_sr;
  end

  always_comb begin
    case (sel)
      SEL_IDENT: dr_lsb = id_sr[0];
      SEL_CHAIN: dr_lsb = chain_sr[CHAIN_LEN-1];
      default:   dr_lsb = pass_q;
    endcase
  end
endmodule

// File: rtl/jtag_tap_ctrl.sv
module jtag_tap_ctrl
  import tap_pkg::*;
#(
  parameter int         CHAIN_LEN = 214,
  parameter logic [3:0] ID_VER    = 4'h2
) (
  input  logic                 tck,
  input  logic                 trst_n,
  input  logic                 tms,
  input  logic                 tdi,
  input  logic [CHAIN_LEN-1:0] bsr_cap_i,
  output logic [CHAIN_LEN-1:0] bsr_upd_o,
  output logic                 tdo,
  output logic                 tdo_oe,
  output logic [IR_W-1:0]      cur_instr_o
);
  tap_state_t tap_state;
  logic       ir_lsb, dr_lsb;
  logic       in_shift_ir, in_shift_dr;

  assign in_shift_ir = (tap_state == ST_IR_SHF);
  assign in_shift_dr = (tap_state == ST_DR_SHF);

  tap_fsm u_fsm (
    .tck(tck), .trst_n(trst_n), .tms(tms), .state(tap_state)
  );

  tap_ir u_ir (
    .tck(tck), .trst_n(trst_n), .tdi(tdi), .state(tap_state),
    .ir_lsb(ir_lsb), .instr(cur_instr_o)
  );

  tap_dr #(.CHAIN_LEN(CHAIN_LEN), .ID_VER(ID_VER)) u_dr (
    .tck(tck), .trst_n(trst_n), .tdi(tdi), .state(tap_state),
    .instr(cur_instr_o), .chain_cap(bsr_cap_i), .chain_upd(bsr_upd_o),
    .dr_lsb(dr_lsb)
  );

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo_oe <= in_shift_ir || in_shift_dr;
      if (in_shift_ir)      tdo <= ir_lsb;
      else if (in_shift_dr) tdo <= dr_lsb;
      else                  tdo <= 1'b0;
    end
  end
endmodule

// File: rtl/tap_chk.sv
module tap_chk
  import tap_pkg::*;
(
  input logic            tck,
  input logic            trst_n,
  input logic            tms,
  input tap_state_t      state,
  input logic [IR_W-1:0] instr,
  input logic            tdo_oe
);
  logic [2:0] ones_run;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)        ones_run <= '0;
    else if (!tms)      ones_run <= '0;
    else if (ones_run != 3'd7) ones_run <= ones_run + 3'd1;
  end

  a_r2_five_ones_reset: assert property (@(posedge tck) disable iff (!trst_n)
    (ones_run >= 3'd5) |-> (state == ST_RESET));

  a_r2_reset_holds_ident: assert property (@(posedge tck) disable iff (!trst_n)
    (state == ST_RESET && $past(state) == ST_RESET) |-> (instr == OP_IDENT));

  a_r4_instr_change_window: assert property (@(posedge tck) disable iff (!trst_n)
    !$stable(instr) |-> (state == ST_IR_UPD || state == ST_RESET));

  a_r9_oe_in_shift: assert property (@(posedge tck) disable iff (!trst_n)
    tdo_oe == (state == ST_IR_SHF || state == ST_DR_SHF));
endmodule

bind jtag_tap_ctrl tap_chk u_chk (
  .tck(tck), .trst_n(trst_n), .tms(tms), .state(tap_state),
  .instr(cur_instr_o), .tdo_oe(tdo_oe)
);

// File: tb/jtag_tap_ctrl_bench.sv
module jtag_tap_ctrl_bench;
  localparam int N = 214;
  localparam logic [3:0] VER = 4'h2;

  logic tck = 1'b0;
  logic trst_n = 1'b0;
  logic tms = 1'b1;
  logic tdi = 1'b0;
  logic [N-1:0] bsr_cap_i;
  logic [N-1:0] bsr_upd_o;
  logic tdo, tdo_oe;
  logic [3:0] cur_instr_o;

  int checks = 0;
  int fails = 0;
  logic last_tdo, last_oe;
  logic oe_bad;

  always #5 tck = ~tck;

  jtag_tap_ctrl #(.CHAIN_LEN(N), .ID_VER(VER)) u_jtag_tap_ctrl (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi),
    .bsr_cap_i(bsr_cap_i), .bsr_upd_o(bsr_upd_o),
    .tdo(tdo), .tdo_oe(tdo_oe), .cur_instr_o(cur_instr_o)
  );

  // opcode, kind (0 pass, 1 ident, 2 chain)
  localparam logic [5:0] VEC [10] = '{
    {4'h5, 2'd1}, {4'hF, 2'd0}, {4'h0, 2'd2}, {4'h3, 2'd0}, {4'h1, 2'd2},
    {4'h7, 2'd0}, {4'h2, 2'd2}, {4'hA, 2'd0}, {4'hE, 2'd0}, {4'h4, 2'd0}
  };

  task automatic chk(input logic ok, input string req, input logic [255:0] act,
                     input logic [255:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(input logic m, input logic d);
    tms = m; tdi = d;
    @(negedge tck); #1;
    last_tdo = tdo; last_oe = tdo_oe;
    @(posedge tck); #1;
  endtask

  task automatic load_ir(input logic [3:0] op, output logic [3:0] cap);
    tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
    for (int i = 0; i < 4; i++) begin
      tick(i == 3, op[i]);
      cap[i] = last_tdo;
      if (!last_oe) oe_bad = 1'b1;
    end
    tick(1, 0); tick(0, 0);
    if (last_oe) oe_bad = 1'b1;
  endtask

  task automatic scan_dr(input int n, input logic [255:0] din, output logic [255:0] dout);
    dout = '0;
    tick(1, 0); tick(0, 0); tick(0, 0);
    for (int i = 0; i < n; i++) begin
      tick(i == n - 1, din[i]);
      dout[i] = last_tdo;
      if (!last_oe) oe_bad = 1'b1;
    end
    tick(1, 0); tick(0, 0);
    if (last_oe) oe_bad = 1'b1;
  endtask

  function automatic logic [31:0] exp_id();
    logic [31:0] w;
    w[0] = 1'b1;
    w[11:1] = 11'd14;
    w[21:12] = 10'd48;
    w[27:22] = 6'd1;
    w[31:28] = VER;
    return w;
  endfunction

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [255:0] din, dout, exp;
    logic [3:0] cap;
    logic [N-1:0] upd_before;
    oe_bad = 1'b0;
    for (int j = 0; j < N; j++) bsr_cap_i[j] = ((j * 7 + j / 3) % 5) < 2;

    #22;
    // R1: reset state under trst
    chk(cur_instr_o == 4'h5, "R1 instr", 256'(cur_instr_o), 256'h5);
    chk(tdo_oe == 1'b0, "R1 oe", 256'(tdo_oe), 256'h0);
    chk(bsr_upd_o == '0, "R1 upd", 256'(bsr_upd_o), 256'h0);
    trst_n = 1'b1;
    @(posedge tck); #1;
    tick(0, 0);

    // R3: IR capture pattern
    load_ir(4'hF, cap);
    chk(cap == 4'b0001, "R3 ir capture", 256'(cap), 256'h1);
    chk(cur_instr_o == 4'hF, "R5 bypass loaded", 256'(cur_instr_o), 256'hF);

    // R4: instruction switch at falling edge of Update-IR
    tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
    for (int i = 0; i < 4; i++) tick(i == 3, 1'(4'h5 >> i));
    tms = 1'b1; @(posedge tck); #1;
    chk(cur_instr_o == 4'hF, "R4 old after rising", 256'(cur_instr_o), 256'hF);
    @(negedge tck); #1;
    chk(cur_instr_o == 4'h5, "R4 new after falling", 256'(cur_instr_o), 256'h5);
    tms = 1'b0; @(posedge tck); #1;

    // Table walk: R5, R6, R7, R8, R9
    for (int k = 0; k < 10; k++) begin
      logic [3:0] op;
      logic [1:0] kind;
      int n;
      op = VEC[k][5:2];
      kind = VEC[k][1:0];
      n = (kind == 2'd2) ? N : 32;
      oe_bad = 1'b0;
      load_ir(op, cap);
      din = '0;
      for (int i = 0; i < n; i++) din[i] = ((i * 3 + k) % 5) < 2;
      upd_before = bsr_upd_o;
      scan_dr(n, din, dout);
      exp = '0;
      if (kind == 2'd0) begin
        for (int i = 1; i < 32; i++) exp[i] = din[i-1];
        chk(dout == exp, "R5 pass-through", dout, exp);
        chk(bsr_upd_o == upd_before, "R8 upd untouched", 256'(bsr_upd_o), 256'(upd_before));
      end else if (kind == 2'd1) begin
        exp[31:0] = exp_id();
        chk(dout == exp, "R6 ident word", dout, exp);
        chk(bsr_upd_o == upd_before, "R8 upd untouched", 256'(bsr_upd_o), 256'(upd_before));
      end else begin
        for (int i = 0; i < N; i++) exp[i] = bsr_cap_i[N-1-i];
        chk(dout == exp, "R7 chain capture", dout, exp);
        exp = '0;
        for (int j = 0; j < N; j++) exp[j] = din[N-1-j];
        chk(256'(bsr_upd_o) == exp, "R8 chain update", 256'(bsr_upd_o), exp);
      end
      chk(!oe_bad, "R9 oe window", 256'(oe_bad), 256'h0);
    end

    // R2: four TMS-high edges from Shift-DR are not enough, five are
    load_ir(4'hF, cap);
    tick(1, 0); tick(0, 0); tick(0, 0);
    tick(1, 0); tick(1, 0); tick(1, 0); tick(1, 0);
    chk(cur_instr_o == 4'hF, "R2 four not enough", 256'(cur_instr_o), 256'hF);
    tick(1, 0);
    tick(1, 0);
    chk(cur_instr_o == 4'h5, "R2 five reach reset", 256'(cur_instr_o), 256'h5);
    chk(last_oe == 1'b0, "R9 oe low in reset", 256'(last_oe), 256'h0);
    tick(0, 0);

    // R1: asynchronous reset mid-scan
    load_ir(4'h1, cap);
    tick(1, 0); tick(0, 0); tick(0, 0);
    tick(0, 1); tick(0, 1);
    chk(tdo_oe == 1'b1, "R9 oe high in shift", 256'(tdo_oe), 256'h1);
    #2 trst_n = 1'b0; #1;
    chk(cur_instr_o == 4'h5, "R1 async instr", 256'(cur_instr_o), 256'h5);
    chk(tdo_oe == 1'b0, "R1 async oe", 256'(tdo_oe), 256'h0);
    chk(bsr_upd_o == '0, "R1 async upd", 256'(bsr_upd_o), 256'h0);
    #10 trst_n = 1'b1;
    @(posedge tck); #1;

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule